// File: doc/BRIEF.md
# Standby Entry and Wake-Up Sequencer

This block moves a processor core between normal execution and one of four standby depths, and brings it back. A halt request comes in with a 2-bit depth code. The block spends a fixed number of clocks completing the entry, and then drops the clock enables for the CPU, the system bus, the peripherals and the oscillator. The depth code decides which of these enables go low. A wake-up interrupt restores the enables. When the core leaves the deepest level, an oscillator warm-up countdown must finish before the CPU clock comes back.

The two deep levels behave differently during the entry window. If a non-maskable request or the external level-0 request arrives while entry is still in progress, the halt is not cancelled. The request is stored as a held request and the halt completes. A later wake-up then reports both requests to the interrupt arbiter: the priority of the request that woke the core, the priority of the held request, and which of the two must be served first. The two shallow levels work as expected: any interrupt during entry cancels the halt at once.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After reset the block is not halted, all four clock enables are 1, and there is no held request and no wake pulse.
- R2: A halt request is accepted only while the block is active. `halted` rises ENTRY_CYC clock edges after the accepting edge, with all enables still 1 during entry. A halt request made while the block is halted has no effect on the enables.
- R3: While halted, the enables {cpu, bus, periph, osc} follow the latched depth code: 00 gives 0111, 01 gives 0011, 10 gives 0001, 11 gives 0000. A low oscillator enable always comes with all other enables low.
- R4: With depth 00 or 01, any interrupt event during entry cancels the halt on that edge. The block is then active again with `wake_pulse` high and no held request.
- R5: With depth 10 or 11, an NMI or INT0 event during entry sets `held_valid` and does not stop entry. `halted` still rises on schedule.
- R6: With depth 10 or 11, only NMI and INT0 events end the halt. An event on the general interrupt input leaves `halted` and all enables unchanged.
- R7: With depth 00, 01 or 10, a wake event while halted returns the block to active on that edge, with `cpu_clk_en` at 1 and a one-cycle `wake_pulse`.
- R8: Leaving depth 11 enables the oscillator alone for `warm_count`+1 cycles after the waking edge (value sampled on that edge). The CPU clock and `wake_pulse` follow on the next edge.
- R9: The waking request's priority appears on `wake_prio`: NMI is 8, and INT0 or the general input carries its 3-bit level. When a request is held, `held_first` is 1 during the wake pulse exactly when the held priority is greater than or equal to `wake_prio`. The held request clears on the edge after the pulse.
- R10: When several NMI or INT0 events arrive during one entry, `held_prio` keeps the highest priority among them.
- R11: `wake_pulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Request to enter standby |
| halt_mode | input | 2 | Standby depth code, sampled with halt_req |
| warm_count | input | WARM_W | Warm-up length for leaving depth 11 |
| nmi_evt | input | 1 | Non-maskable interrupt event |
| int0_evt | input | 1 | External wake interrupt event |
| int0_lvl | input | LVL_W | Priority level of int0_evt (1..7) |
| irq_evt | input | 1 | General interrupt event |
| irq_lvl | input | LVL_W | Priority level of irq_evt (1..7) |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | System bus and interrupt logic clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| halted | output | 1 | Standby fully entered |
| wake_pulse | output | 1 | One-cycle pulse on return to active |
| wake_prio | output | LVL_W+1 | Priority of the request that woke the block |
| held_valid | output | 1 | A request caught during entry is being held |
| held_prio | output | LVL_W+1 | Priority of the held request |
| held_first | output | 1 | Held request is to be served before the waking one |

## Verification
The assertions take for granted that interrupt events are single-cycle pulses, that every asserted level is in the range 1 to 7, and that reset is held from time zero through at least one clock edge. The directed tasks drive every event for exactly one cycle, with a nonzero level on it. They place entry-window events at chosen entry cycles, and they return all inputs to idle before each check, so the wake priorities and held priorities the bench computes depend only on the events it has issued.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_IDLE2 = 2'b01,
    MODE_IDLE1 = 2'b10,
    MODE_STOP  = 2'b11
  } stby_mode_e;

  typedef enum logic [1:0] {
    ST_ACTIVE,
    ST_ENTER,
    ST_HALT,
    ST_WARM
  } stby_state_e;

  typedef struct packed {
    logic cpu;
    logic bus;
    logic per;
    logic osc;
  } clk_en_t;

  function automatic logic is_deep(stby_mode_e m);
    return m[1];
  endfunction

  // enables seen in each sequencer state
  function automatic clk_en_t state_mask(stby_state_e s, stby_mode_e m);
    clk_en_t r;
    r = clk_en_t'(4'b1111);
    if (s == ST_WARM) r = clk_en_t'(4'b0001);
    else if (s == ST_HALT) begin
      case (m)
        MODE_RUN:   r = clk_en_t'(4'b0111);
        MODE_IDLE2: r = clk_en_t'(4'b0011);
        MODE_IDLE1: r = clk_en_t'(4'b0001);
        default:    r = clk_en_t'(4'b0000);
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/stby_warm.sv
module stby_warm #(
  parameter int WARM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WARM_W-1:0] load_val,
  output logic              done
);
  logic [WARM_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // a loaded count only moves down by one per cycle
  assert_warm_down_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/stby_hold.sv
module stby_hold #(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [PRIO_W-1:0] cap_prio,
  input  logic              rel_en,
  input  logic [PRIO_W-1:0] rel_prio,
  input  logic              clr,
  output logic              held_valid,
  output logic [PRIO_W-1:0] held_prio,
  output logic [PRIO_W-1:0] wake_prio,
  output logic              held_first
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      held_prio  <= '0;
      wake_prio  <= '0;
      held_first <= 1'b0;
    end else begin
      if (clr) begin
        held_valid <= 1'b0;
        held_prio  <= '0;
        held_first <= 1'b0;
      end
      if (cap_en) begin
        held_valid <= 1'b1;
        if (!held_valid || cap_prio > held_prio) held_prio <= cap_prio;
      end
      if (rel_en) begin
        wake_prio  <= rel_prio;
        held_first <= held_valid && (held_prio >= rel_prio);
      end
    end
  end

  // a held request only leaves through a wake
  assert_held_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (held_valid && !clr) |=> held_valid);
  assert_first_needs_held_R9: assert property (@(posedge clk) disable iff (rst)
    held_first |-> held_valid);
endmodule

// File: rtl/stby_seq.sv
module stby_seq
  import stby_pkg::*;
#(
  parameter int ENTRY_CYC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_req,
  input  stby_mode_e halt_mode,
  input  logic       deep_evt,
  input  logic       any_evt,
  input  logic       warm_done,
  output logic       warm_load,
  output logic       cap_en,
  output logic       rel_en,
  output stby_mode_e mode_o,
  output clk_en_t    clk_en,
  output logic       halted,
  output logic       wake_pulse
);
  localparam int ENT_W = $clog2(ENTRY_CYC + 1);

  stby_state_e      st_q, st_d;
  stby_mode_e       mode_q, mode_d;
  logic [ENT_W-1:0] ent_q, ent_d;
  logic             go;
  logic             wake_ev;

  assign wake_ev = is_deep(mode_q) ? deep_evt : any_evt;

  always_comb begin
    st_d      = st_q;
    mode_d    = mode_q;
    ent_d     = ent_q;
    go        = 1'b0;
    warm_load = 1'b0;
    cap_en    = 1'b0;
    rel_en    = 1'b0;
    case (st_q)
      ST_ACTIVE: if (halt_req) begin
        st_d   = ST_ENTER;
        mode_d = halt_mode;
        ent_d  = '0;
      end
      ST_ENTER: begin
        cap_en = is_deep(mode_q) && deep_evt;
        if (!is_deep(mode_q) && any_evt) begin
          st_d   = ST_ACTIVE;
          rel_en = 1'b1;
          go     = 1'b1;
        end else if (ent_q == ENT_W'(ENTRY_CYC - 1)) st_d = ST_HALT;
        else ent_d = ent_q + 1'b1;
      end
      ST_HALT: if (wake_ev) begin
        rel_en = 1'b1;
        if (mode_q == MODE_STOP) begin
          st_d      = ST_WARM;
          warm_load = 1'b1;
        end else begin
          st_d = ST_ACTIVE;
          go   = 1'b1;
        end
      end
      default: if (warm_done) begin
        st_d = ST_ACTIVE;
        go   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_ACTIVE;
      mode_q     <= MODE_RUN;
      ent_q      <= '0;
      clk_en     <= clk_en_t'(4'b1111);
      halted     <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      st_q       <= st_d;
      mode_q     <= mode_d;
      ent_q      <= ent_d;
      clk_en     <= state_mask(st_d, mode_d);
      halted     <= (st_d == ST_HALT);
      wake_pulse <= go;
    end
  end

  assign mode_o = mode_q;

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
  assert_wake_runs_cpu_R7: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (clk_en.cpu && !halted));
  assert_entry_keeps_clocks_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ENTER) |-> (clk_en == clk_en_t'(4'b1111)));
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int ENTRY_CYC = 3,
  parameter int WARM_W    = 16,
  parameter int LVL_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic [1:0]        halt_mode,
  input  logic [WARM_W-1:0] warm_count,
  input  logic              nmi_evt,
  input  logic              int0_evt,
  input  logic [LVL_W-1:0]  int0_lvl,
  input  logic              irq_evt,
  input  logic [LVL_W-1:0]  irq_lvl,
  output logic              cpu_clk_en,
  output logic              bus_clk_en,
  output logic              periph_clk_en,
  output logic              osc_en,
  output logic              halted,
  output logic              wake_pulse,
  output logic [LVL_W:0]    wake_prio,
  output logic              held_valid,
  output logic [LVL_W:0]    held_prio,
  output logic              held_first
);
  localparam int            PRIO_W = LVL_W + 1;
  localparam logic [LVL_W:0] NMI_P = PRIO_W'(1) << LVL_W;

  logic [PRIO_W-1:0] deep_p, any_p, rel_p;
  logic              deep_evt, any_evt;
  logic              warm_load, warm_done, cap_en, rel_en;
  stby_mode_e        mode_q;
  clk_en_t           en;

  assign deep_evt = nmi_evt | int0_evt;
  assign any_evt  = deep_evt | irq_evt;

  always_comb begin
    deep_p = '0;
    if (nmi_evt)       deep_p = NMI_P;
    else if (int0_evt) deep_p = {1'b0, int0_lvl};
    any_p = deep_p;
    if (irq_evt && {1'b0, irq_lvl} > any_p) any_p = {1'b0, irq_lvl};
  end

  assign rel_p = is_deep(mode_q) ? deep_p : any_p;

  stby_seq #(.ENTRY_CYC(ENTRY_CYC)) u_seq (
    .clk(clk), .rst(rst), .halt_req(halt_req),
    .halt_mode(stby_mode_e'(halt_mode)),
    .deep_evt(deep_evt), .any_evt(any_evt), .warm_done(warm_done),
    .warm_load(warm_load), .cap_en(cap_en), .rel_en(rel_en),
    .mode_o(mode_q), .clk_en(en), .halted(halted), .wake_pulse(wake_pulse)
  );

  stby_warm #(.WARM_W(WARM_W)) u_warm (
    .clk(clk), .rst(rst), .load(warm_load), .load_val(warm_count),
    .done(warm_done)
  );

  stby_hold #(.PRIO_W(PRIO_W)) u_hold (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_prio(deep_p),
    .rel_en(rel_en), .rel_prio(rel_p), .clr(wake_pulse),
    .held_valid(held_valid), .held_prio(held_prio),
    .wake_prio(wake_prio), .held_first(held_first)
  );

  assign cpu_clk_en    = en.cpu;
  assign bus_clk_en    = en.bus;
  assign periph_clk_en = en.per;
  assign osc_en        = en.osc;

  assert_osc_gates_all_R3: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !(cpu_clk_en || bus_clk_en || periph_clk_en));
  assert_held_deep_only_R5: assert property (@(posedge clk) disable iff (rst)
    held_valid |-> is_deep(mode_q));
  assert_stop_exit_warm_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(halted) && mode_q == MODE_STOP) |-> (!cpu_clk_en && osc_en));
endmodule

// File: tb/test_standby_wake_ctrl.sv
module test_standby_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_req = 1'b0;
  logic [1:0] halt_mode = 2'b00;
  logic [15:0] warm_count = '0;
  logic       nmi_evt = 1'b0, int0_evt = 1'b0, irq_evt = 1'b0;
  logic [2:0] int0_lvl = 3'd1, irq_lvl = 3'd1;
  logic       cpu_clk_en, bus_clk_en, periph_clk_en, osc_en;
  logic       halted, wake_pulse, held_valid, held_first;
  logic [3:0] wake_prio, held_prio;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  standby_wake_ctrl i_standby_wake_ctrl (
    .clk(clk), .rst(rst), .halt_req(halt_req), .halt_mode(halt_mode),
    .warm_count(warm_count), .nmi_evt(nmi_evt), .int0_evt(int0_evt),
    .int0_lvl(int0_lvl), .irq_evt(irq_evt), .irq_lvl(irq_lvl),
    .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .halted(halted),
    .wake_pulse(wake_pulse), .wake_prio(wake_prio), .held_valid(held_valid),
    .held_prio(held_prio), .held_first(held_first)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ens();
    return {cpu_clk_en, bus_clk_en, periph_clk_en, osc_en};
  endfunction

  task automatic idle_inputs();
    halt_req = 0; nmi_evt = 0; int0_evt = 0; irq_evt = 0;
  endtask

  // accept edge, then entry
  task automatic accept(logic [1:0] m);
    halt_req = 1; halt_mode = m; tick(); halt_req = 0;
  endtask

  task automatic enter_halt(logic [1:0] m);
    accept(m); tick(); tick(); tick();
  endtask

  task automatic pulse_nmi(); nmi_evt = 1; tick(); nmi_evt = 0; endtask
  task automatic pulse_int0(logic [2:0] l); int0_evt = 1; int0_lvl = l; tick(); int0_evt = 0; endtask
  task automatic pulse_irq(logic [2:0] l); irq_evt = 1; irq_lvl = l; tick(); irq_evt = 0; endtask

  task automatic t_reset();
    chk("R1", "halted", halted, 0);
    chk("R1", "enables", ens(), 4'b1111);
    chk("R1", "held_valid", held_valid, 0);
    chk("R1", "wake_pulse", wake_pulse, 0);
  endtask

  task automatic t_entry_run();
    accept(2'b00);
    chk("R2", "enables in entry", ens(), 4'b1111);
    tick(); tick();
    chk("R2", "halted before window end", halted, 0);
    tick();
    chk("R2", "halted at window end", halted, 1);
    chk("R3", "RUN mask", ens(), 4'b0111);
    halt_req = 1; halt_mode = 2'b11; tick(); halt_req = 0;
    chk("R2", "second request ignored", ens(), 4'b0111);
    pulse_irq(3'd4);
    chk("R7", "wake pulse", wake_pulse, 1);
    chk("R7", "cpu back", cpu_clk_en, 1);
    chk("R9", "wake_prio irq", wake_prio, 4);
    tick();
    chk("R11", "pulse single", wake_pulse, 0);
  endtask

  task automatic t_masks();
    enter_halt(2'b01);
    chk("R3", "IDLE2 mask", ens(), 4'b0011);
    pulse_nmi();
    chk("R7", "IDLE2 wake", cpu_clk_en, 1);
    tick();
    enter_halt(2'b10);
    chk("R3", "IDLE1 mask", ens(), 4'b0001);
    pulse_int0(3'd2);
    chk("R7", "IDLE1 wake", wake_pulse, 1);
    tick();
    warm_count = 0;
    enter_halt(2'b11);
    chk("R3", "STOP mask", ens(), 4'b0000);
    pulse_nmi();
    chk("R8", "zero warm osc only", ens(), 4'b0001);
    tick();
    chk("R8", "zero warm resume", cpu_clk_en, 1);
    chk("R8", "zero warm pulse", wake_pulse, 1);
    tick();
  endtask

  task automatic t_shallow_abort();
    accept(2'b01);
    pulse_irq(3'd3);
    chk("R4", "halted", halted, 0);
    chk("R4", "pulse", wake_pulse, 1);
    chk("R4", "held", held_valid, 0);
    chk("R4", "enables", ens(), 4'b1111);
    tick();
  endtask

  task automatic t_deep_hold();
    accept(2'b10);
    tick();
    pulse_nmi();
    chk("R5", "held_valid", held_valid, 1);
    chk("R5", "held_prio nmi", held_prio, 8);
    chk("R5", "still entering", halted, 0);
    tick();
    chk("R5", "halt completes", halted, 1);
    pulse_irq(3'd7);
    chk("R6", "irq ignored halted", halted, 1);
    chk("R6", "irq ignored enables", ens(), 4'b0001);
    pulse_int0(3'd3);
    chk("R9", "pulse", wake_pulse, 1);
    chk("R9", "wake_prio", wake_prio, 3);
    chk("R9", "held first", held_first, 1);
    tick();
    chk("R9", "held cleared", held_valid, 0);
  endtask

  task automatic t_stop_reverse();
    warm_count = 2;
    accept(2'b11);
    pulse_int0(3'd2);
    pulse_int0(3'd6);
    pulse_int0(3'd4);
    chk("R10", "highest kept", held_prio, 6);
    chk("R5", "halted", halted, 1);
    pulse_irq(3'd7);
    chk("R6", "irq ignored in STOP", ens(), 4'b0000);
    pulse_nmi();
    chk("R8", "warm osc only", ens(), 4'b0001);
    tick(); tick();
    chk("R8", "still warming", cpu_clk_en, 0);
    tick();
    chk("R8", "cpu after warm", cpu_clk_en, 1);
    chk("R9", "wake_prio nmi", wake_prio, 8);
    chk("R9", "held not first", held_first, 0);
    chk("R9", "held visible", held_valid, 1);
    tick();
    chk("R9", "held cleared", held_valid, 0);
  endtask

  task automatic t_tie();
    accept(2'b10);
    tick(); tick();
    pulse_int0(3'd5);
    chk("R5", "edge-of-window hold", held_valid, 1);
    chk("R5", "halted", halted, 1);
    pulse_int0(3'd5);
    chk("R9", "tie held first", held_first, 1);
    tick();
  endtask

  task automatic t_warm_long();
    warm_count = 4;
    enter_halt(2'b11);
    pulse_int0(3'd1);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8", "cpu low in warm", cpu_clk_en, 0);
    end
    tick();
    chk("R8", "cpu after N+1", cpu_clk_en, 1);
    chk("R11", "pulse", wake_pulse, 1);
    tick();
    chk("R11", "pulse ends", wake_pulse, 0);
  endtask

  initial begin
    idle_inputs();
    tick(); tick();
    rst = 0;
    t_reset();
    t_entry_run();
    t_masks();
    t_shallow_abort();
    t_deep_hold();
    t_stop_reverse();
    t_tie();
    t_warm_long();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule